// File: doc/BRIEF.md
# Privileged Counter-Reset Write Arbiter

This block decides what happens when software attempts a write to a protected register that clears event counters. Each request carries the privilege level of the requester (0 to 3). The block samples a set of configuration inputs alongside it: whether the feature exists, which higher levels exist or are enabled, the monitor-trap bits, the user-access enables and the fine-grained trap controls. From these it resolves exactly one outcome: the write is performed, the instruction is treated as undefined, or the access traps to a higher level with a fixed syndrome class.

The outcome is resolved by an ordered list of checks whose membership depends on the requesting level. The first check that fires wins. The result is registered and presented one cycle later with a valid strobe. The block neither updates the counters nor delivers the exception. Downstream logic consumes the registered result and acts on it.

Top module: `priv_wr_arbiter`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge yields `rsp_valid` high in the following cycle. `rsp_valid` is low in any cycle not preceded by a request, and it is low out of reset.
- R2: `rsp_kind` encodes the outcome as 2'b00 perform, 2'b01 undefined and 2'b10 trap, and never shows 2'b11. When the outcome is not a trap, `rsp_target` and `rsp_class` read zero.
- R3: With `feat_impl` low, every request is undefined at every level, including level 3.
- R4: With `feat_impl` high, a level-3 request is always performed, whatever the other inputs.
- R5: At levels 0, 1 and 2, the highest-priority check is `lvl3_exists` && `sdd_undef_prio` && `mon3_trap`. When it holds, the result is undefined, ahead of every trap check.
- R6: At level 0 only, the next check fires when `usr_en` and `usr_zero_en` are both low. It traps to level 2 if `lvl2_enabled` and `host_route` are both high, and to level 1 otherwise.
- R7: At levels 0 and 1, the next check traps to level 2 when `lvl2_enabled` and `fgt_impl` are high and either (`lvl3_exists` and not `fg3_enable`) or not `fg2_wr_permit`. At level 0 this check is skipped when `lvl0_host` is high. It never applies at level 2.
- R8: At levels 0 and 1, the next check traps to level 2 when `lvl2_enabled` and `mon2_trap` are high. It never applies at level 2.
- R9: At levels 0, 1 and 2, the last check fires when `lvl3_exists` and `mon3_trap` are high. It gives undefined if `sdd_undef` is high and a trap to level 3 otherwise. If no check fires, the write is performed, so a trap target is always above the requesting level.
- R10: Every trap outcome carries `rsp_class` = 8'h18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_level | input | 2 | Privilege level of the requester |
| feat_impl | input | 1 | Counter-reset register feature present |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| lvl3_exists | input | 1 | Level 3 is implemented |
| lvl2_enabled | input | 1 | Level 2 is enabled for the current state |
| lvl0_host | input | 1 | Level 0 runs in host mode |
| sdd_undef_prio | input | 1 | Secure-debug undefined-priority condition |
| sdd_undef | input | 1 | Secure-debug undefined condition |
| mon3_trap | input | 1 | Level-3 monitor-trap control |
| mon2_trap | input | 1 | Level-2 monitor-trap control |
| usr_en | input | 1 | User access enable |
| usr_zero_en | input | 1 | User counter-reset enable |
| host_route | input | 1 | Route user-level traps to level 2 |
| fg3_enable | input | 1 | Level-3 fine-grained trap enable |
| fg2_wr_permit | input | 1 | Level-2 per-register write permit (low traps) |
| rsp_valid | output | 1 | Result strobe |
| rsp_kind | output | 2 | Outcome: 00 perform, 01 undefined, 10 trap |
| rsp_target | output | 2 | Trap target level, zero otherwise |
| rsp_class | output | 8 | Syndrome class, 8'h18 on a trap, zero otherwise |

## Verification
The hardest outcome to reach is the fine-grained trap from level 0. Several conditions have to line up for it. The level-0 user enable check must be satisfied so it does not shadow the fine-grained check, host mode must be off, and level 2 must be enabled with the fine-grained controls set. The directed table sets `usr_en` so that the earlier check passes. It then toggles `lvl0_host`, `fg3_enable` and `fg2_wr_permit` one at a time, so that each term is seen to decide the result. A long pseudo-random sweep follows and is compared against a priority model written from the requirements. The sweep reaches the shadowing combinations that the table does not list.

// File: rtl/priv_wr_pkg.sv
package priv_wr_pkg;

  localparam int LVL_W   = 2;
  localparam int CLASS_W = 8;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 8'h18;

  typedef enum logic [1:0] {
    RES_PERFORM = 2'b00,
    RES_UNDEF   = 2'b01,
    RES_TRAP    = 2'b10
  } res_kind_e;

  typedef struct packed {
    logic feat_impl;
    logic fgt_impl;
    logic lvl3_exists;
    logic lvl2_enabled;
    logic lvl0_host;
    logic sdd_undef_prio;
    logic sdd_undef;
    logic mon3_trap;
    logic mon2_trap;
    logic usr_en;
    logic usr_zero_en;
    logic host_route;
    logic fg3_enable;
    logic fg2_wr_permit;
  } ctrl_t;

  typedef struct packed {
    logic             hit;
    res_kind_e        kind;
    logic [LVL_W-1:0] target;
  } chk_t;

  // Ordered check slots, lower index wins
  localparam int CHK_NOFEAT = 0;
  localparam int CHK_TOP    = 1;
  localparam int CHK_SDDPRI = 2;
  localparam int CHK_USER   = 3;
  localparam int CHK_FGT    = 4;
  localparam int CHK_MON2   = 5;
  localparam int CHK_MON3   = 6;
  localparam int N_CHK      = 7;

endpackage

// File: rtl/priv_wr_cond.sv
module priv_wr_cond
  import priv_wr_pkg::*;
(
  input  logic [LVL_W-1:0]   level,
  input  ctrl_t              ctrl,
  output chk_t [N_CHK-1:0]   chk
);

  logic at0, at1, at3, below3, below2;
  logic fg_cond;
  logic [LVL_W-1:0] user_tgt;

  always_comb begin
    at0    = (level == 2'd0);
    at1    = (level == 2'd1);
    at3    = (level == 2'd3);
    below3 = !at3;
    below2 = at0 || at1;

    fg_cond = ctrl.lvl2_enabled && ctrl.fgt_impl &&
              ((ctrl.lvl3_exists && !ctrl.fg3_enable) || !ctrl.fg2_wr_permit);

    user_tgt = (ctrl.lvl2_enabled && ctrl.host_route) ? 2'd2 : 2'd1;

    chk[CHK_NOFEAT] = '{hit: !ctrl.feat_impl, kind: RES_UNDEF, target: '0};

    chk[CHK_TOP]    = '{hit: at3, kind: RES_PERFORM, target: '0};

    chk[CHK_SDDPRI] = '{hit: below3 && ctrl.lvl3_exists && ctrl.sdd_undef_prio && ctrl.mon3_trap,
                        kind: RES_UNDEF, target: '0};

    chk[CHK_USER]   = '{hit: at0 && !ctrl.usr_en && !ctrl.usr_zero_en,
                        kind: RES_TRAP, target: user_tgt};

    chk[CHK_FGT]    = '{hit: ((at0 && !ctrl.lvl0_host) || at1) && fg_cond,
                        kind: RES_TRAP, target: 2'd2};

    chk[CHK_MON2]   = '{hit: below2 && ctrl.lvl2_enabled && ctrl.mon2_trap,
                        kind: RES_TRAP, target: 2'd2};

    chk[CHK_MON3]   = '{hit: below3 && ctrl.lvl3_exists && ctrl.mon3_trap,
                        kind: ctrl.sdd_undef ? RES_UNDEF : RES_TRAP,
                        target: ctrl.sdd_undef ? 2'd0 : 2'd3};
  end

endmodule

// File: rtl/priv_wr_prio.sv
module priv_wr_prio
  import priv_wr_pkg::*;
(
  input  chk_t [N_CHK-1:0] chk,
  output res_kind_e        kind,
  output logic [LVL_W-1:0] target
);

  logic [N_CHK:0]   seen;
  logic [N_CHK-1:0] sel;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_CHK; i++) begin : g_chain
    assign sel[i]      = chk[i].hit && !seen[i];
    assign seen[i + 1] = seen[i] || chk[i].hit;
  end

  always_comb begin
    logic [1:0] k;
    k      = '0;
    target = '0;
    for (int i = 0; i < N_CHK; i++) begin
      if (sel[i]) begin
        k      = k | chk[i].kind;
        target = target | chk[i].target;
      end
    end
    kind = res_kind_e'(k);
  end

endmodule

// File: rtl/priv_wr_outreg.sv
module priv_wr_outreg
  import priv_wr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  res_kind_e          in_kind,
  input  logic [LVL_W-1:0]   in_target,
  output logic               out_valid,
  output logic [1:0]         out_kind,
  output logic [LVL_W-1:0]   out_target,
  output logic [CLASS_W-1:0] out_class
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_kind   <= '0;
      out_target <= '0;
      out_class  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind   <= in_kind;
        out_target <= (in_kind == RES_TRAP) ? in_target : '0;
        out_class  <= (in_kind == RES_TRAP) ? TRAP_CLASS : '0;
      end
    end
  end

endmodule

// File: rtl/priv_wr_arbiter.sv
module priv_wr_arbiter
  import priv_wr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LVL_W-1:0]   req_level,
  input  logic               feat_impl,
  input  logic               fgt_impl,
  input  logic               lvl3_exists,
  input  logic               lvl2_enabled,
  input  logic               lvl0_host,
  input  logic               sdd_undef_prio,
  input  logic               sdd_undef,
  input  logic               mon3_trap,
  input  logic               mon2_trap,
  input  logic               usr_en,
  input  logic               usr_zero_en,
  input  logic               host_route,
  input  logic               fg3_enable,
  input  logic               fg2_wr_permit,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind,
  output logic [LVL_W-1:0]   rsp_target,
  output logic [CLASS_W-1:0] rsp_class
);

  ctrl_t            ctrl;
  chk_t [N_CHK-1:0] chk;
  res_kind_e        res_kind;
  logic [LVL_W-1:0] res_target;

  assign ctrl = '{
    feat_impl:      feat_impl,
    fgt_impl:       fgt_impl,
    lvl3_exists:    lvl3_exists,
    lvl2_enabled:   lvl2_enabled,
    lvl0_host:      lvl0_host,
    sdd_undef_prio: sdd_undef_prio,
    sdd_undef:      sdd_undef,
    mon3_trap:      mon3_trap,
    mon2_trap:      mon2_trap,
    usr_en:         usr_en,
    usr_zero_en:    usr_zero_en,
    host_route:     host_route,
    fg3_enable:     fg3_enable,
    fg2_wr_permit:  fg2_wr_permit
  };

  priv_wr_cond u_cond (
    .level (req_level),
    .ctrl  (ctrl),
    .chk   (chk)
  );

  priv_wr_prio u_prio (
    .chk    (chk),
    .kind   (res_kind),
    .target (res_target)
  );

  priv_wr_outreg u_oreg (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (req_valid),
    .in_kind    (res_kind),
    .in_target  (res_target),
    .out_valid  (rsp_valid),
    .out_kind   (rsp_kind),
    .out_target (rsp_target),
    .out_class  (rsp_class)
  );

endmodule

// File: rtl/priv_wr_arbiter_chk.sv
module priv_wr_arbiter_chk
  import priv_wr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [LVL_W-1:0]   req_level,
  input logic               feat_impl,
  input logic               lvl3_exists,
  input logic               sdd_undef_prio,
  input logic               mon3_trap,
  input logic               rsp_valid,
  input logic [1:0]         rsp_kind,
  input logic [LVL_W-1:0]   rsp_target,
  input logic [CLASS_W-1:0] rsp_class
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_kind != 2'b11);

  a_r2_quiet_fields: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != RES_TRAP) |-> (rsp_target == '0 && rsp_class == '0));

  a_r3_nofeat_undef: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !feat_impl) |=> rsp_kind == RES_UNDEF);

  a_r4_top_performs: assert property (@(posedge clk) disable iff (rst)
    (req_valid && feat_impl && req_level == 2'd3) |=> rsp_kind == RES_PERFORM);

  a_r5_sdd_first: assert property (@(posedge clk) disable iff (rst)
    (req_valid && feat_impl && req_level != 2'd3 && lvl3_exists && sdd_undef_prio && mon3_trap)
      |=> rsp_kind == RES_UNDEF);

  a_r9_target_above: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_kind != RES_TRAP || rsp_target > $past(req_level)));

  a_r10_class: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RES_TRAP) |-> rsp_class == TRAP_CLASS);

endmodule

bind priv_wr_arbiter priv_wr_arbiter_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_level      (req_level),
  .feat_impl      (feat_impl),
  .lvl3_exists    (lvl3_exists),
  .sdd_undef_prio (sdd_undef_prio),
  .mon3_trap      (mon3_trap),
  .rsp_valid      (rsp_valid),
  .rsp_kind       (rsp_kind),
  .rsp_target     (rsp_target),
  .rsp_class      (rsp_class)
);

// File: tb/priv_wr_arbiter_tb_top.sv
`timescale 1ns/1ps
module priv_wr_arbiter_tb_top;

  // cfg bit positions: 13 feat,12 fgt,11 l3,10 l2en,9 host0,8 sddp,7 sdd,
  // 6 mon3,5 mon2,4 uen,3 uzen,2 route,1 fg3en,0 fg2wp
  localparam int N_VEC = 25;
  localparam int N_RND = 3000;
  // entry: {level[1:0], cfg[13:0], kind[1:0], target[1:0]}
  localparam logic [19:0] VEC [N_VEC] = '{
    {2'd0, 14'h2013, 2'b00, 2'd0},  // R6 user enabled, perform
    {2'd0, 14'h0013, 2'b01, 2'd0},  // R3
    {2'd3, 14'h0013, 2'b01, 2'd0},  // R3 at level 3
    {2'd3, 14'h2973, 2'b00, 2'd0},  // R4
    {2'd1, 14'h2953, 2'b01, 2'd0},  // R5
    {2'd0, 14'h2003, 2'b10, 2'd1},  // R6 trap to 1
    {2'd0, 14'h2407, 2'b10, 2'd2},  // R6 host route
    {2'd0, 14'h2007, 2'b10, 2'd1},  // R6 route without l2
    {2'd0, 14'h200B, 2'b00, 2'd0},  // R6 zero enable
    {2'd0, 14'h2943, 2'b01, 2'd0},  // R5 beats R6
    {2'd1, 14'h2003, 2'b00, 2'd0},  // R6 only at level 0
    {2'd1, 14'h3412, 2'b10, 2'd2},  // R7 write permit low
    {2'd0, 14'h3412, 2'b10, 2'd2},  // R7 level 0
    {2'd0, 14'h3612, 2'b00, 2'd0},  // R7 host mode exempt
    {2'd1, 14'h3C11, 2'b10, 2'd2},  // R7 l3 fg enable low
    {2'd1, 14'h2C11, 2'b00, 2'd0},  // R7 needs fgt
    {2'd1, 14'h2433, 2'b10, 2'd2},  // R8
    {2'd2, 14'h2433, 2'b00, 2'd0},  // R8 not at level 2
    {2'd2, 14'h3412, 2'b00, 2'd0},  // R7 not at level 2
    {2'd2, 14'h2853, 2'b10, 2'd3},  // R9 trap to 3
    {2'd2, 14'h28D3, 2'b01, 2'd0},  // R9 undefined
    {2'd1, 14'h2053, 2'b00, 2'd0},  // R9 needs l3
    {2'd0, 14'h2433, 2'b10, 2'd2},  // R8 level 0
    {2'd1, 14'h2C73, 2'b10, 2'd2},  // R8 before R9
    {2'd0, 14'h3402, 2'b10, 2'd1}   // R6 before R7
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_level = '0;
  logic [13:0] cfg = '0;
  logic       rsp_valid;
  logic [1:0] rsp_kind;
  logic [1:0] rsp_target;
  logic [7:0] rsp_class;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  priv_wr_arbiter dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .feat_impl(cfg[13]), .fgt_impl(cfg[12]), .lvl3_exists(cfg[11]),
    .lvl2_enabled(cfg[10]), .lvl0_host(cfg[9]), .sdd_undef_prio(cfg[8]),
    .sdd_undef(cfg[7]), .mon3_trap(cfg[6]), .mon2_trap(cfg[5]),
    .usr_en(cfg[4]), .usr_zero_en(cfg[3]), .host_route(cfg[2]),
    .fg3_enable(cfg[1]), .fg2_wr_permit(cfg[0]),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_target(rsp_target),
    .rsp_class(rsp_class)
  );

  // Priority model written from R3..R9
  function automatic logic [3:0] model(input logic [1:0] l, input logic [13:0] c);
    logic fgc;
    fgc = c[10] && c[12] && ((c[11] && !c[1]) || !c[0]);
    if (!c[13])                              return {2'b01, 2'd0};
    if (l == 2'd3)                           return {2'b00, 2'd0};
    if (c[11] && c[8] && c[6])               return {2'b01, 2'd0};
    if (l == 2'd0 && !c[4] && !c[3])         return {2'b10, (c[10] && c[2]) ? 2'd2 : 2'd1};
    if (((l == 2'd0 && !c[9]) || l == 2'd1) && fgc) return {2'b10, 2'd2};
    if (l != 2'd2 && c[10] && c[5])          return {2'b10, 2'd2};
    if (c[11] && c[6])                       return c[7] ? {2'b01, 2'd0} : {2'b10, 2'd3};
    return {2'b00, 2'd0};
  endfunction

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b k=%b t=%0d c=%h, expected v=%b k=%b t=%0d c=%h", req,
               got[12], got[11:10], got[9:8], got[7:0], exp[12], exp[11:10], exp[9:8], exp[7:0]);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] l, input logic [13:0] c,
                       input logic [3:0] exp);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = l;
    cfg       = c;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: trap class, R2: zero fields otherwise
    check(req, {rsp_valid, rsp_kind, rsp_target, rsp_class},
          {1'b1, exp, (exp[3:2] == 2'b10) ? 8'h18 : 8'h00});
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {rsp_valid, rsp_kind, rsp_target, rsp_class}, 13'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", {rsp_valid, 12'h0}, 13'h0);

    for (int i = 0; i < N_VEC; i++)
      apply("R2-R10 table", VEC[i][19:18], VEC[i][17:4], VEC[i][3:0]);

    // R1: no request means no valid
    @(negedge clk);
    check("R1 no request", {rsp_valid, 12'h0}, 13'h0);

    // R3/R4 exhaustive over level with feature on/off
    for (int l = 0; l < 4; l++) begin
      apply("R3 all levels", 2'(l), 14'h1FFF, 4'b0100);
      apply("R4/R9 model", 2'(l), 14'h3FFF, model(2'(l), 14'h3FFF));
    end

    // Pseudo-random sweep against model (R5-R9)
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < N_RND; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply("R5-R9 sweep", lfsr[17:16], {1'b1, lfsr[12:0]} ^ {lfsr[20], 13'h0},
            model(lfsr[17:16], {1'b1, lfsr[12:0]} ^ {lfsr[20], 13'h0}));
    end

    // R1: reset while a result is held drops valid
    @(negedge clk);
    req_valid = 1'b1;
    cfg = 14'h2003;
    req_level = 2'd0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {rsp_valid, rsp_kind, rsp_target, rsp_class}, 13'h0);
    req_valid = 1'b0;
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule